// File: doc/BRIEF.md
# I2C Master Command Engine

This block is a bus master for a two-wire serial bus. Software drives it one command at a time. There are six commands:

- start a transfer;
- restart a transfer without giving up the bus;
- shift out one byte, which is either an address or data;
- shift in one byte;
- send an acknowledge or a not-acknowledge after a received byte;
- end the transfer.

Each command runs as a fixed list of bus steps. A step is half of a serial clock period. A reload counter sets how long each step lasts, in system clock cycles.

Both bus lines are open-drain. The engine drives a pull-low enable for each line, and an external pull-up makes a released line read high. While a command runs, the engine compares the data line with the level it expects each time it releases the line. If another master holds the line low, the engine drops both lines at once, abandons the command and raises a bus-collision flag. The engine has no command queue. A byte write made while a command is still running is discarded and raises a write-collision flag.

The first byte after a start is the 7-bit target address followed by the direction bit: 0 to write to the target, 1 to read from it. Software chooses the reload value for a 100 kHz, 400 kHz or 1 MHz serial clock.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset both line enables are 0 (lines released), and busy, write-collision and bus-collision are all 0.
- R2: A start, accepted while idle, produces three steps:
  - SDA and SCL released (SDA must read high at the end of this step);
  - SDA pulled low with SCL released;
  - both pulled low.
- R3: Every step lasts reload+1 system clock cycles. The reload value is 7 bits. The step clock starts when a command is accepted and stops when its last step ends. SCL then keeps its last level while the engine is idle.
- R4: A byte write shifts 8 bits MSB first. Each bit uses two steps: a low SCL step with SDA = bit, then a high SCL step. After the 8 bits, the engine releases SDA for an acknowledge bit and samples SDA at the end of its high step into rx_ack (0 = acknowledged). A final step leaves SCL low and SDA released.
- R5: A byte read keeps SDA released for 8 bit periods. At the end of each high SCL step it shifts SDA into rx_data, MSB first. A final step leaves SCL low.
- R6: An acknowledge command runs one bit period, pulling SDA low when ack_val is 0 and releasing it when ack_val is 1. A final step leaves SCL low and SDA released.
- R7: A repeated start runs four steps, starting from SCL low:
  - SDA released with SCL low;
  - both released;
  - SDA low;
  - both low.

  SCL is never left released at the end of it.
- R8: A stop runs three steps:
  - both low;
  - SCL released;
  - both released (SDA must read high at the end of this step).
- R9: While busy, a byte write does not change the buffer and sets wcol one cycle later. Any other command issued while busy is ignored, and the running waveform is unchanged.
- R10: If the engine has released SDA and expects a 1, and SDA reads 0 at the end of that step, then on that edge it releases both lines, drops busy and sets bcol. The steps that check SDA are: a start's first step, a repeated start's second step, the high step of a 1-bit being written, a not-acknowledge high step, and a stop's last step.
- R11: Accepting a new command clears wcol and bcol on the same edge that raises busy.
- R12: If several commands arrive in one cycle, the engine keeps only the one highest in this order: start, repeated start, stop, byte write, byte read, acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reload | input | 7 | Step length minus one, in clock cycles |
| cmd_start | input | 1 | Start command pulse |
| cmd_rstart | input | 1 | Repeated start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_read | input | 1 | Receive-one-byte command pulse |
| cmd_ack | input | 1 | Send acknowledge bit command pulse |
| ack_val | input | 1 | Acknowledge level to send (0 = ACK, 1 = NACK) |
| buf_wr | input | 1 | Byte write: loads buf_data and starts shifting it out |
| buf_data | input | 8 | Byte to transmit |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Last received byte |
| rx_ack | output | 1 | Acknowledge bit sampled after a written byte |
| busy | output | 1 | A command is running |
| wcol | output | 1 | Write collision flag |
| bcol | output | 1 | Bus collision (arbitration lost) flag |

## Verification
A command accepted at a clock edge shows its first step on the line enables and busy right after that edge. Each later step appears reload+1 cycles after the one before it. bcol rises on the edge that ends the failing check step. wcol follows a rejected write one cycle later. rx_data and rx_ack are stable once busy has fallen.

The bench model builds each command's expected waveform as a queue with one entry per cycle. It pops one entry at every falling clock edge and compares it there with the enables, busy and both flags. rx_data and rx_ack are checked only after busy drops. The simulated target pulls SDA low from the same queue entry, so its response lines up with the engine's sampling edge.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_START, OP_RSTART, OP_STOP, OP_WRITE, OP_READ, OP_ACK
  } op_e;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
    logic chk_high;
    logic smp_rx;
    logic smp_ack;
    logic last;
  } step_t;
endpackage

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
  import i2c_eng_pkg::*;
(
  input  logic cmd_start,
  input  logic cmd_rstart,
  input  logic cmd_stop,
  input  logic buf_wr,
  input  logic cmd_read,
  input  logic cmd_ack,
  output op_e  op
);
  // fixed priority between simultaneous pulses
  always_comb begin
    if (cmd_start)       op = OP_START;
    else if (cmd_rstart) op = OP_RSTART;
    else if (cmd_stop)   op = OP_STOP;
    else if (buf_wr)     op = OP_WRITE;
    else if (cmd_read)   op = OP_READ;
    else if (cmd_ack)    op = OP_ACK;
    else                 op = OP_NONE;
  end
endmodule

// File: rtl/i2c_baud_tick.sv
module i2c_baud_tick #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                run,
  input  logic [RELOAD_W-1:0] reload,
  output logic                tick
);
  logic [RELOAD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= reload;
    else if (run && cnt_q == '0) cnt_q <= reload;
    else if (run)                cnt_q <= cnt_q - 1'b1;
  end

  assign tick = run && !load && (cnt_q == '0);
endmodule

// File: rtl/i2c_step_pattern.sv
module i2c_step_pattern
  import i2c_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STEP_W = 5
) (
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  input  logic [DATA_W-1:0] data,
  input  logic              ack_val,
  output step_t             pat
);
  localparam int BIT_STEPS = 2 * DATA_W;

  logic [DATA_W-1:0] shifted;
  logic              cur_bit;
  logic              in_bits;

  assign shifted = data << step[STEP_W-1:1];
  assign cur_bit = shifted[DATA_W-1];
  assign in_bits = (int'(step) < BIT_STEPS);

  always_comb begin
    pat = '0;
    unique case (op)
      OP_START: begin
        pat.chk_high = (step == 0);
        pat.sda_low  = (step != 0);
        pat.scl_low  = (step == 2);
        pat.last     = (step >= 2);
      end
      OP_RSTART: begin
        pat.scl_low  = (step == 0) || (step == 3);
        pat.sda_low  = (step >= 2);
        pat.chk_high = (step == 1);
        pat.last     = (step >= 3);
      end
      OP_STOP: begin
        pat.scl_low  = (step == 0);
        pat.sda_low  = (step <= 1);
        pat.chk_high = (step == 2);
        pat.last     = (step >= 2);
      end
      OP_WRITE: begin
        if (in_bits) begin
          pat.scl_low  = !step[0];
          pat.sda_low  = !cur_bit;
          pat.chk_high = step[0] && cur_bit;
        end else begin
          pat.scl_low = (int'(step) != BIT_STEPS + 1);
          pat.smp_ack = (int'(step) == BIT_STEPS + 1);
          pat.last    = (int'(step) >= BIT_STEPS + 2);
        end
      end
      OP_READ: begin
        if (in_bits) begin
          pat.scl_low = !step[0];
          pat.smp_rx  = step[0];
        end else begin
          pat.scl_low = 1'b1;
          pat.last    = 1'b1;
        end
      end
      OP_ACK: begin
        pat.scl_low  = (step != 1);
        pat.sda_low  = (step <= 1) && !ack_val;
        pat.chk_high = (step == 1) && ack_val;
        pat.last     = (step >= 2);
      end
      default: pat.last = 1'b1;
    endcase
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_eng_pkg::*;
#(
  parameter int RELOAD_W = 7,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                cmd_start,
  input  logic                cmd_rstart,
  input  logic                cmd_stop,
  input  logic                cmd_read,
  input  logic                cmd_ack,
  input  logic                ack_val,
  input  logic                buf_wr,
  input  logic [DATA_W-1:0]   buf_data,
  input  logic                sda_in,
  output logic                scl_oe,
  output logic                sda_oe,
  output logic [DATA_W-1:0]   rx_data,
  output logic                rx_ack,
  output logic                busy,
  output logic                wcol,
  output logic                bcol
);
  localparam int MAX_STEP = 2 * DATA_W + 3;
  localparam int STEP_W   = $clog2(MAX_STEP + 1);

  op_e               dec_op, op_q, pat_op;
  logic              busy_q, wcol_q, bcol_q, scl_q, sda_q, rxack_q, ackv_q;
  logic              accept, tick, pat_ackv;
  logic [STEP_W-1:0] step_q, pat_step;
  logic [DATA_W-1:0] wbuf_q, rx_q, pat_data;
  step_t             cur_pat, nxt_pat;

  i2c_cmd_decode u_dec (
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .buf_wr(buf_wr), .cmd_read(cmd_read), .cmd_ack(cmd_ack), .op(dec_op)
  );

  assign accept = !busy_q && (dec_op != OP_NONE);

  i2c_baud_tick #(.RELOAD_W(RELOAD_W)) u_baud (
    .clk(clk), .rst(rst), .load(accept), .run(busy_q),
    .reload(reload), .tick(tick)
  );

  // pattern of the step now on the bus
  i2c_step_pattern #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_cur (
    .op(op_q), .step(step_q), .data(wbuf_q), .ack_val(ackv_q), .pat(cur_pat)
  );

  // pattern of the step about to be entered
  assign pat_op   = accept ? dec_op : op_q;
  assign pat_step = accept ? '0 : step_q + 1'b1;
  assign pat_data = accept ? buf_data : wbuf_q;
  assign pat_ackv = accept ? ack_val : ackv_q;

  i2c_step_pattern #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_nxt (
    .op(pat_op), .step(pat_step), .data(pat_data), .ack_val(pat_ackv), .pat(nxt_pat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      op_q    <= OP_NONE;
      step_q  <= '0;
      wbuf_q  <= '0;
      ackv_q  <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      rx_q    <= '0;
      rxack_q <= 1'b0;
      wcol_q  <= 1'b0;
      bcol_q  <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= dec_op;
      step_q <= '0;
      ackv_q <= ack_val;
      wcol_q <= 1'b0;
      bcol_q <= 1'b0;
      scl_q  <= nxt_pat.scl_low;
      sda_q  <= nxt_pat.sda_low;
      if (dec_op == OP_WRITE) wbuf_q <= buf_data;
    end else begin
      if (busy_q && buf_wr) wcol_q <= 1'b1;
      if (tick) begin
        if (cur_pat.chk_high && !sda_in) begin
          bcol_q <= 1'b1;
          busy_q <= 1'b0;
          scl_q  <= 1'b0;
          sda_q  <= 1'b0;
        end else begin
          if (cur_pat.smp_rx)  rx_q    <= {rx_q[DATA_W-2:0], sda_in};
          if (cur_pat.smp_ack) rxack_q <= sda_in;
          if (cur_pat.last) begin
            busy_q <= 1'b0;
          end else begin
            step_q <= step_q + 1'b1;
            scl_q  <= nxt_pat.scl_low;
            sda_q  <= nxt_pat.sda_low;
          end
        end
      end
    end
  end

  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;
  assign rx_data = rx_q;
  assign rx_ack  = rxack_q;
  assign busy    = busy_q;
  assign wcol    = wcol_q;
  assign bcol    = bcol_q;

  // R9
  wcol_set_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && buf_wr) |=> wcol_q);

  // R10
  bcol_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bcol_q) |-> (!scl_q && !sda_q && !busy_q));

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (!wcol_q && !bcol_q));

  // R3
  scl_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !$past(busy_q)) |-> $stable(scl_q));

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_q) && op_q == OP_START) |-> (!scl_q && !sda_q));
endmodule

// File: tb/tb_i2c_cmd_engine.sv
`timescale 1ns/100ps
module tb_i2c_cmd_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] reload = 7'd3;
  logic       cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_read = 0, cmd_ack = 0;
  logic       ack_val = 0, buf_wr = 0;
  logic [7:0] buf_data = '0;
  logic       sda_in;
  logic       scl_oe, sda_oe, rx_ack, busy, wcol, bcol;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  typedef struct packed { logic scl; logic sda; logic pull; } ent_t;
  ent_t q[$];

  int   tests = 0, fails = 0, cycles = 0;
  logic cur_pull = 0, model_on = 0;
  logic idle_scl = 0, idle_sda = 0, fin_bcol = 0;
  logic exp_wcol = 0;

  assign sda_in = !(sda_oe || cur_pull);

  i2c_cmd_engine dut (
    .clk(clk), .rst(rst), .reload(reload), .cmd_start(cmd_start), .cmd_rstart(cmd_rstart),
    .cmd_stop(cmd_stop), .cmd_read(cmd_read), .cmd_ack(cmd_ack), .ack_val(ack_val),
    .buf_wr(buf_wr), .buf_data(buf_data), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_data(rx_data), .rx_ack(rx_ack), .busy(busy), .wcol(wcol), .bcol(bcol)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle reference comparison: {scl_oe, sda_oe, busy, wcol, bcol}
  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      logic [4:0] e;
      if (q.size() != 0) begin
        ent_t x;
        x = q.pop_front();
        cur_pull = x.pull;
        e = {x.scl, x.sda, 1'b1, exp_wcol, 1'b0};
      end else begin
        cur_pull = 1'b0;
        e = {idle_scl, idle_sda, 1'b0, exp_wcol, fin_bcol};
      end
      check({scl_oe, sda_oe, busy, wcol, bcol} == e, "R2/R3/R4/R7/R8/R9/R10 waveform",
            {27'd0, scl_oe, sda_oe, busy, wcol, bcol}, {27'd0, e});
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic push(input logic s, input logic d, input logic p);
    repeat (int'(reload) + 1) q.push_back({s, d, p});
    idle_scl = s;
    idle_sda = d;
  endtask

  task automatic collide();
    idle_scl = 0;
    idle_sda = 0;
    fin_bcol = 1;
  endtask

  task automatic begin_cmd();
    @(negedge clk); #1;
    exp_wcol = 0;
    fin_bcol = 0;
  endtask

  task automatic end_pulse();
    @(posedge clk); #1;
    cmd_start = 0; cmd_rstart = 0; cmd_stop = 0; cmd_read = 0; cmd_ack = 0; buf_wr = 0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_start(input bit col);
    begin_cmd();
    cmd_start = 1;
    push(0, 0, col);
    if (col) collide();
    else begin push(0, 1, 0); push(1, 1, 0); end
    end_pulse();
    wait_idle();
  endtask

  task automatic do_rstart();
    begin_cmd();
    cmd_rstart = 1;
    push(1, 0, 0); push(0, 0, 0); push(0, 1, 0); push(1, 1, 0);
    end_pulse();
    wait_idle();
  endtask

  task automatic do_stop();
    begin_cmd();
    cmd_stop = 1;
    push(1, 1, 0); push(0, 1, 0); push(0, 0, 0);
    end_pulse();
  endtask

  // R4: byte write, MSB first; ack_low = target acknowledges; col = lose on MSB
  task automatic issue_write(input logic [7:0] d, input bit ack_low, input bit col);
    begin_cmd();
    buf_wr = 1;
    buf_data = d;
    for (int i = 7; i >= 0; i--) begin
      push(1, !d[i], 0);
      push(0, !d[i], (col && i == 7));
      if (col && i == 7) begin collide(); break; end
    end
    if (!col) begin push(1, 0, ack_low); push(0, 0, ack_low); push(1, 0, 0); end
    end_pulse();
  endtask

  task automatic do_read(input logic [7:0] d);
    begin_cmd();
    cmd_read = 1;
    for (int i = 7; i >= 0; i--) begin push(1, 0, !d[i]); push(0, 0, !d[i]); end
    push(1, 0, 0);
    end_pulse();
    wait_idle();
    check(rx_data == d, "R5 rx_data", {24'd0, rx_data}, {24'd0, d});
  endtask

  task automatic do_ack(input logic a);
    begin_cmd();
    cmd_ack = 1;
    ack_val = a;
    push(1, !a, 0); push(0, !a, 0); push(1, 0, 0);
    end_pulse();
    wait_idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check({scl_oe, sda_oe, busy, wcol, bcol} == 5'b0, "R1 reset outputs",
          {27'd0, scl_oe, sda_oe, busy, wcol, bcol}, 32'd0);
    #1 rst = 0;
    @(negedge clk); #1 model_on = 1;

    do_start(0);                                // R2
    issue_write(8'hA4, 1, 0); wait_idle();      // R4 address + write, acked
    check(rx_ack == 1'b0, "R4 rx_ack ack", {31'd0, rx_ack}, 32'd0);

    // R9: rejected write and ignored stop during a running write
    issue_write(8'h3C, 0, 0);
    repeat (5) @(negedge clk);
    #1 buf_wr = 1; buf_data = 8'hFF; exp_wcol = 1;
    @(posedge clk); #1 buf_wr = 0;
    @(negedge clk); #1 cmd_stop = 1;
    @(posedge clk); #1 cmd_stop = 0;
    wait_idle();
    check(rx_ack == 1'b1, "R4 rx_ack nack", {31'd0, rx_ack}, 32'd1);
    check(wcol == 1'b1, "R9 wcol set", {31'd0, wcol}, 32'd1);

    do_rstart();                                // R7, R11 wcol cleared
    check(wcol == 1'b0, "R11 wcol cleared", {31'd0, wcol}, 32'd0);
    issue_write(8'hA5, 1, 0); wait_idle();
    do_read(8'h96);                             // R5
    do_ack(0);                                  // R6 ACK
    do_read(8'h01);
    do_ack(1);                                  // R6 NACK
    do_stop(); wait_idle();                     // R8

    // R12: start wins over simultaneous write and stop
    begin_cmd();
    cmd_start = 1; buf_wr = 1; buf_data = 8'h00; cmd_stop = 1;
    push(0, 0, 0); push(0, 1, 0); push(1, 1, 0);
    end_pulse();
    wait_idle();

    // R3 with the shortest step
    reload = 7'd0;
    issue_write(8'hFF, 1, 0); wait_idle();
    do_stop(); wait_idle();

    // R10 arbitration loss during start, then during a write MSB
    reload = 7'd9;
    do_start(1);
    check(bcol == 1'b1, "R10 bcol start", {31'd0, bcol}, 32'd1);
    do_start(0);
    check(bcol == 1'b0, "R11 bcol cleared", {31'd0, bcol}, 32'd0);
    issue_write(8'h80, 1, 1); wait_idle();
    check({bcol, scl_oe, sda_oe} == 3'b100, "R10 released on loss",
          {29'd0, bcol, scl_oe, sda_oe}, 32'd4);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule